// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits between a 16-bit memory bus and a small two-partition flash array model. A processor talks to it with ordinary write cycles, putting 8-bit command codes on the low data byte. The block decodes these codes and moves each partition between its read views: array contents, status, identifier words and query words. Commands take one bus write, or two when a setup code is followed by a data or confirm write. Program and erase jobs run on a shared internal write engine. The engine is only a countdown of a fixed number of clocks, and at the end it applies the result to the array model.

The partition is chosen by the top address bit. Each partition keeps its own read mode and its own error flags. The ready and suspend flags come from the shared engine. A running job can be suspended, the array can be read while it is parked, and the job can then be resumed from the count where it stopped. While a job is actually running, only the status and suspend commands take effect. Every other write is dropped.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset both partitions are in read-array mode, every array word reads FFFFh, and a status read returns 80h.
- R2: The read outputs are active (dq_en=1) only while ce_n=0, oe_n=0 and we_n=1. At all other times dq_en=0 and dq_out=0000h. A bus write is a clock edge with ce_n=0, we_n=0 and oe_n=1, and its command code is dq_in[7:0].
- R3: Code 40h or 10h followed by a second write latches that write's address and data, and puts the addressed partition in status mode. PROG_CYCLES clocks later the word holds old AND data, so bits only go from 1 to 0.
- R4: Code 20h followed by D0h erases the aligned BLK_WORDS block holding the second write's address to FFFFh, ERASE_CYCLES clocks later. Words outside that block are unchanged.
- R5: If the write after 20h is not D0h, no erase starts. The addressed partition's erase-error and sequence-error bits are set, and that partition is left in status mode.
- R6: The partition is addr[AW-1] and the offset is addr[AW-2:0]. Code 70h puts only the addressed partition in status mode. A status read returns {00h, SR} with SR bit7 = ready, bit6 = suspended (shown on the job's partition), bit5 = erase error, bit4 = sequence error, and bits 3:0 = 0.
- R7: SR bit7 is 0 from the write that starts a job until the job completes, and 1 afterwards.
- R8: While a job is running and not suspended, only 70h and B0h take effect. Any other write, such as FFh, leaves modes and array unchanged.
- R9: B0h during a running job sets SR bit7 and bit6 to 1 from the next cycle on and freezes the count. The array stays unchanged while the job is suspended. A following D0h clears bit6 and bit7 and finishes the remaining count.
- R10: Code 50h clears bits 5 and 4 of the addressed partition only. It does not change bit7 or the read mode.
- R11: Code 90h selects identifier reads: offset 0 gives MFR_ID, offset 1 gives DEV_ID, and other offsets give 0000h. Code 98h selects query reads: offsets 0, 1 and 2 give 0051h, 0052h and 0059h, and other offsets give 0000h.
- R12: Code FFh returns the addressed partition to read-array mode. After 60h or C0h, the next write is consumed with no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Word address; top bit picks the partition |
| dq_in | input | 16 | Write data; low byte carries commands |
| dq_out | output | 16 | Read data, 0000h when not driven |
| dq_en | output | 1 | Output driver enable (low means high-impedance) |

## Verification
The bench builds the block with AW=5, BLK_WORDS=8, PROG_CYCLES=6 and ERASE_CYCLES=12. With these values each partition holds two erase blocks, so a neighbour word outside an erased block can be checked. A job finishes in a handful of cycles, so busy status, command gating during a run, suspend partway through an erase, and completion after resume can all be observed one after another in a short run. Identifier and query words are read at in-range and out-of-range offsets in both partitions.

// File: rtl/fci_pkg.sv
package fci_pkg;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_t;
  typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_ERASE, PD_PROT} pend_t;

  localparam logic [7:0] CMD_PROG     = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT = 8'h10;
  localparam logic [7:0] CMD_ERASE    = 8'h20;
  localparam logic [7:0] CMD_CLR      = 8'h50;
  localparam logic [7:0] CMD_PROT     = 8'h60;
  localparam logic [7:0] CMD_STAT     = 8'h70;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_SUSP     = 8'hB0;
  localparam logic [7:0] CMD_PLOCK    = 8'hC0;
  localparam logic [7:0] CMD_CONF     = 8'hD0;
  localparam logic [7:0] CMD_ARRAY    = 8'hFF;

  function automatic logic [7:0] status_byte(input logic ready, input logic susp,
                                             input logic eerr, input logic serr);
    return {ready, susp, eerr, serr, 4'h0};
  endfunction

  function automatic logic [15:0] ident_word(input int unsigned off,
                                             input logic [15:0] mfr,
                                             input logic [15:0] dev);
    if (off == 0) return mfr;
    if (off == 1) return dev;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] query_word(input int unsigned off);
    case (off)
      0: return 16'h0051;
      1: return 16'h0052;
      2: return 16'h0059;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] program_word(input logic [15:0] old_w,
                                               input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

endpackage

// File: rtl/fci_part_state.sv
module fci_part_state
  import fci_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   set_mode,
  input  rmode_t mode_val,
  input  logic   set_err,
  input  logic   clr_err,
  output rmode_t mode,
  output logic   erase_err,
  output logic   seq_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= RM_ARRAY;
      erase_err <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      if (set_mode) mode <= mode_val;
      if (set_err) begin
        erase_err <= 1'b1;
        seq_err   <= 1'b1;
      end else if (clr_err) begin
        erase_err <= 1'b0;
        seq_err   <= 1'b0;
      end
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_err && !clr_err) |=> $stable({erase_err, seq_err})); // R10

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_err |=> (erase_err && seq_err)); // R5

endmodule

// File: rtl/fci_write_engine.sv
module fci_write_engine #(
  parameter int PROG_CYCLES  = 40,
  parameter int ERASE_CYCLES = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_erase,
  input  logic suspend_req,
  input  logic resume_req,
  output logic busy,
  output logic running,
  output logic suspended,
  output logic done,
  output logic job_erase
);

  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNTW = $clog2(MAXC + 1);

  logic [CNTW-1:0] cnt_q;

  assign running = busy && !suspended;
  assign done    = running && (cnt_q == CNTW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      suspended <= 1'b0;
      job_erase <= 1'b0;
      cnt_q     <= '0;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      suspended <= 1'b0;
      job_erase <= start_erase;
      cnt_q     <= start_erase ? CNTW'(ERASE_CYCLES) : CNTW'(PROG_CYCLES);
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (running) begin
      if (suspend_req) suspended <= 1'b1;
      else             cnt_q     <= cnt_q - CNTW'(1);
    end else if (suspended && resume_req) begin
      suspended <= 1'b0;
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R3

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !resume_req) |=> ($stable(cnt_q) && busy)); // R9

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !running); // R7

  AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/fci_array.sv
module fci_array
  import fci_pkg::*;
#(
  parameter int AW        = 5,
  parameter int BLK_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          fire_erase,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);

  localparam int WORDS    = 2 ** AW;
  localparam int BLK_BITS = $clog2(BLK_WORDS);

  logic [15:0] mem_q [WORDS];
  logic [15:0] targ_word;

  assign rdata     = mem_q[raddr];
  assign targ_word = mem_q[waddr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= 16'hFFFF;
    end else if (fire) begin
      if (fire_erase) begin
        for (int i = 0; i < WORDS; i++) begin
          if ((AW'(i) >> BLK_BITS) == (waddr >> BLK_BITS)) mem_q[i] <= 16'hFFFF;
        end
      end else begin
        mem_q[waddr] <= program_word(mem_q[waddr], wdata);
      end
    end
  end

  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !fire_erase) |=> ((targ_word & ~$past(targ_word)) == 16'h0000)); // R3

  AST_ERASE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && fire_erase) |=> (targ_word == 16'hFFFF)); // R4

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fci_pkg::*;
#(
  parameter int          AW           = 5,
  parameter int          BLK_WORDS    = 8,
  parameter int          PROG_CYCLES  = 40,
  parameter int          ERASE_CYCLES = 120,
  parameter logic [15:0] MFR_ID       = 16'h002C,
  parameter logic [15:0] DEV_ID       = 16'h44C3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_en
);

  localparam int NPART = 2;

  logic        wr_stb, part;
  logic [7:0]  code;
  pend_t       pend_q, pend_d;
  logic [NPART-1:0] set_mode, set_err, clr_err;
  rmode_t      mode_val;
  rmode_t      part_mode [NPART];
  logic [NPART-1:0] eerr, serr;
  logic [7:0]  sr_byte [NPART];

  logic eng_start, eng_start_erase, susp_req, res_req, latch;
  logic eng_busy, eng_running, eng_susp, eng_done, eng_erase;

  logic [AW-1:0] job_addr;
  logic [15:0]   job_data;
  logic          job_part;

  logic [15:0] arr_rdata, rd_word;
  logic [AW-2:0] off;

  assign wr_stb = !ce_n && !we_n && oe_n;
  assign part   = addr[AW-1];
  assign off    = addr[AW-2:0];
  assign code   = dq_in[7:0];

  always_comb begin
    pend_d          = pend_q;
    set_mode        = '0;
    mode_val        = RM_STATUS;
    set_err         = '0;
    clr_err         = '0;
    eng_start       = 1'b0;
    eng_start_erase = 1'b0;
    susp_req        = 1'b0;
    res_req         = 1'b0;
    latch           = 1'b0;
    if (wr_stb) begin
      if (eng_running) begin
        if (code == CMD_STAT) set_mode[part] = 1'b1;
        if (code == CMD_SUSP) susp_req = 1'b1;
      end else begin
        unique case (pend_q)
          PD_PROG: begin
            eng_start      = 1'b1;
            latch          = 1'b1;
            set_mode[part] = 1'b1;
            pend_d         = PD_NONE;
          end
          PD_ERASE: begin
            set_mode[part] = 1'b1;
            pend_d         = PD_NONE;
            if (code == CMD_CONF) begin
              eng_start       = 1'b1;
              eng_start_erase = 1'b1;
              latch           = 1'b1;
            end else begin
              set_err[part] = 1'b1;
            end
          end
          PD_PROT: pend_d = PD_NONE;
          default: begin
            case (code)
              CMD_PROG, CMD_PROG_ALT: if (!eng_susp) pend_d = PD_PROG;
              CMD_ERASE:              if (!eng_susp) pend_d = PD_ERASE;
              CMD_PROT, CMD_PLOCK:    pend_d = PD_PROT;
              CMD_CLR:                clr_err[part] = 1'b1;
              CMD_STAT:  set_mode[part] = 1'b1;
              CMD_IDENT: begin set_mode[part] = 1'b1; mode_val = RM_IDENT; end
              CMD_QUERY: begin set_mode[part] = 1'b1; mode_val = RM_QUERY; end
              CMD_ARRAY: begin set_mode[part] = 1'b1; mode_val = RM_ARRAY; end
              CMD_CONF:  if (eng_susp) res_req = 1'b1;
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= PD_NONE;
      job_addr <= '0;
      job_data <= '0;
      job_part <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (latch) begin
        job_addr <= addr;
        job_data <= dq_in;
        job_part <= part;
      end
    end
  end

  for (genvar p = 0; p < NPART; p++) begin : g_part
    fci_part_state u_ps (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_mode  (set_mode[p]),
      .mode_val  (mode_val),
      .set_err   (set_err[p]),
      .clr_err   (clr_err[p]),
      .mode      (part_mode[p]),
      .erase_err (eerr[p]),
      .seq_err   (serr[p])
    );
    assign sr_byte[p] = status_byte(!eng_running, eng_susp && (job_part == 1'(p)),
                                    eerr[p], serr[p]);
  end

  fci_write_engine #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (eng_start),
    .start_erase (eng_start_erase),
    .suspend_req (susp_req),
    .resume_req  (res_req),
    .busy        (eng_busy),
    .running     (eng_running),
    .suspended   (eng_susp),
    .done        (eng_done),
    .job_erase   (eng_erase)
  );

  fci_array #(
    .AW        (AW),
    .BLK_WORDS (BLK_WORDS)
  ) u_arr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (eng_done),
    .fire_erase (eng_erase),
    .waddr      (job_addr),
    .wdata      (job_data),
    .raddr      (addr),
    .rdata      (arr_rdata)
  );

  always_comb begin
    case (part_mode[part])
      RM_STATUS: rd_word = {8'h00, sr_byte[part]};
      RM_IDENT:  rd_word = ident_word(32'(off), MFR_ID, DEV_ID);
      RM_QUERY:  rd_word = query_word(32'(off));
      default:   rd_word = arr_rdata;
    endcase
  end

  assign dq_en  = !ce_n && !oe_n && we_n;
  assign dq_out = dq_en ? rd_word : 16'h0000;

  AST_DQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n || !we_n) |-> (dq_out == 16'h0000)); // R2

  AST_STATUS_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_en && part_mode[part] == RM_STATUS) |-> (dq_out[15:8] == 8'h00)); // R6

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_running && wr_stb && code == CMD_ARRAY)
      |=> ($stable(part_mode[0]) && $stable(part_mode[1]))); // R8

  AST_SEQ_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !eng_running && pend_q == PD_ERASE && code != CMD_CONF) |-> !eng_start); // R5

  AST_CLEAR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !eng_running && pend_q == PD_NONE && code == CMD_CLR) |=> !eng_running); // R10

endmodule

// File: tb/flash_cmd_if_bench.sv
module flash_cmd_if_bench;

  localparam int AW = 5;
  localparam int PC = 6;
  localparam int EC = 12;
  localparam logic [15:0] MFR = 16'h002C;
  localparam logic [15:0] DEV = 16'h44C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic dq_en;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [16:0] exp_q [$];
  string       tag_q [$];
  event        rd_go;

  always #4 clk = ~clk;

  flash_cmd_if #(
    .AW(AW), .BLK_WORDS(8), .PROG_CYCLES(PC), .ERASE_CYCLES(EC),
    .MFR_ID(MFR), .DEV_ID(DEV)
  ) u_flash_cmd_if (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_en(dq_en)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; dq_in = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [15:0] exp,
                    input logic exp_en, input logic ce, input string tag);
    @(negedge clk);
    ce_n = ce; we_n = 1'b1; oe_n = 1'b0; addr = a;
    exp_q.push_back({exp_en, exp_en ? exp : 16'h0000});
    tag_q.push_back(tag);
    -> rd_go;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(rd_go);
      #2;
      begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({dq_en, dq_out} !== e) begin
          n_bad++;
          $display("FAIL %s: got en=%0b data=%04h, expected en=%0b data=%04h",
                   t, dq_en, dq_out, e[16], e[15:0]);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : driver
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(5'd3,  16'hFFFF, 1, 0, "R1 array p0");
    rd(5'd20, 16'hFFFF, 1, 0, "R1 array p1");
    // R2 disabled outputs
    rd(5'd3,  16'h0000, 0, 1, "R2 ce_n high");
    wr(5'd0, 16'h0070);
    rd(5'd0,  16'h0080, 1, 0, "R1 status after reset");
    rd(5'd16, 16'hFFFF, 1, 0, "R6 other partition stays array");
    // R3 program, R7 busy, R8 gating
    wr(5'd2, 16'h0040);
    wr(5'd2, 16'hA5F0);
    rd(5'd2,  16'h0000, 1, 0, "R7 ready low while programming");
    wr(5'd2, 16'h00FF);
    rd(5'd2,  16'h0000, 1, 0, "R8 FFh ignored while busy");
    idle(PC + 4);
    rd(5'd2,  16'h0080, 1, 0, "R7 ready after program");
    wr(5'd2, 16'h00FF);
    rd(5'd2,  16'hA5F0, 1, 0, "R3 programmed word");
    wr(5'd2, 16'h0010);
    wr(5'd2, 16'h0FFF);
    idle(PC + 4);
    wr(5'd2, 16'h00FF);
    rd(5'd2,  16'h05F0, 1, 0, "R3 second program ANDs");
    wr(5'd5, 16'h0040); wr(5'd5, 16'h1234); idle(PC + 4);
    wr(5'd9, 16'h0040); wr(5'd9, 16'h00FF); idle(PC + 4);
    wr(5'd18, 16'h0040); wr(5'd18, 16'h0F0F); idle(PC + 4);
    // R4 erase with R9 suspend/resume
    wr(5'd4, 16'h0020);
    wr(5'd4, 16'h00D0);
    wr(5'd4, 16'h00B0);
    rd(5'd4,  16'h00C0, 1, 0, "R9 suspended status");
    wr(5'd4, 16'h00FF);
    idle(EC + 8);
    rd(5'd2,  16'h05F0, 1, 0, "R9 array unchanged while suspended");
    wr(5'd4, 16'h00D0);
    wr(5'd4, 16'h0070);
    rd(5'd4,  16'h0000, 1, 0, "R9 resumed job running");
    idle(EC + 4);
    rd(5'd4,  16'h0080, 1, 0, "R7 ready after erase");
    wr(5'd0, 16'h00FF);
    rd(5'd2,  16'hFFFF, 1, 0, "R4 erased word 2");
    rd(5'd5,  16'hFFFF, 1, 0, "R4 erased word 5");
    rd(5'd9,  16'h00FF, 1, 0, "R4 neighbour block kept");
    // R5 sequence error in partition 1
    wr(5'd17, 16'h0020);
    wr(5'd17, 16'h00FF);
    rd(5'd17, 16'h00B0, 1, 0, "R5 error bits and status mode");
    wr(5'd0, 16'h0070);
    rd(5'd0,  16'h0080, 1, 0, "R6 partition 0 status unaffected");
    wr(5'd17, 16'h00FF);
    rd(5'd18, 16'h0F0F, 1, 0, "R5 no erase started");
    // R10 clear status
    wr(5'd17, 16'h0020);
    wr(5'd17, 16'h0011);
    wr(5'd17, 16'h0050);
    rd(5'd17, 16'h0080, 1, 0, "R10 errors cleared, ready kept");
    // R11 identifier and query
    wr(5'd0, 16'h0090);
    rd(5'd0,  MFR,      1, 0, "R11 ident offset 0");
    rd(5'd1,  DEV,      1, 0, "R11 ident offset 1");
    rd(5'd2,  16'h0000, 1, 0, "R11 ident other offset");
    wr(5'd16, 16'h0098);
    rd(5'd16, 16'h0051, 1, 0, "R11 query offset 0");
    rd(5'd17, 16'h0052, 1, 0, "R11 query offset 1");
    rd(5'd18, 16'h0059, 1, 0, "R11 query offset 2");
    rd(5'd19, 16'h0000, 1, 0, "R11 query other offset");
    rd(5'd1,  DEV,      1, 0, "R6 partition 0 keeps ident mode");
    // R12 read array and consumed protection writes
    wr(5'd0, 16'h00FF);
    rd(5'd9,  16'h00FF, 1, 0, "R12 back to array");
    wr(5'd0, 16'h0060);
    wr(5'd0, 16'h0070);
    rd(5'd9,  16'h00FF, 1, 0, "R12 60h consumes next write");
    wr(5'd0, 16'h00C0);
    wr(5'd0, 16'h0090);
    rd(5'd0,  16'hFFFF, 1, 0, "R12 C0h consumes next write");
    idle(2);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule